// File: doc/BRIEF.md
# Third-Order One-Bit Noise-Shaping Modulator

This block turns a stream of oversampled signed words, one word per tick from an upstream interpolator, into a one-bit density stream. The loop is a chain of three saturating accumulators. Each accumulator adds its input minus the fed-back quantised level, so the quantisation error is pushed out of the low-frequency band toward high frequencies. A later analog low-pass filter of order four or higher can then remove that noise. The sign of the last accumulator is the output bit.

The bit drives a true pin and an inverted pin. An optional strobe pin rises while each new bit is stable, so that external flip-flops on a clean supply can retime the pair. The `enable` pin is the only control. While it is low, everything returns to a fixed idle state.

Input words arrive over a valid/ready handshake. A word is taken on any clock edge where `s_valid` and `s_ready` are both high. `s_ready` follows `enable`, except in the single cycle after an accepted word, when it is low while the new bit is resolved. The upstream stage holds `s_data` stable while `s_valid` is high and `s_ready` is low. Words therefore enter at most every second clock.

Top module: `sdm3_modulator`

## Requirements
- R1: After reset, and while `enable` is low, `bit_p`, `bit_n`, `bit_clk` and `s_ready` are all 0.
- R2: `s_ready` equals `enable`, except that it is 0 in the cycle directly after a clock edge that accepted a word.
- R3: Once a bit has been produced, and until `enable` drops, `bit_n` is always the inverse of `bit_p`.
- R4: On each accepted word x, with v = +2^(DATA_W-1) if `bit_p` is 1 and -2^(DATA_W-1) if it is 0, the three accumulators update together from their previous values: a0 += x - v, a1 += a0 - v, a2 += a1 - v.
- R5: One clock edge after the accepting edge, `bit_p` becomes 1 if a2 is zero or positive and 0 if it is negative, and `bit_n` becomes the inverse.
- R6: Each accumulator is DATA_W+4 bits, signed. It clamps to its most positive or most negative value instead of wrapping when a sum overflows.
- R7: On edges that accept no word, the accumulators keep their values, and the bit outputs change only as R5 and R9 demand.
- R8: With CLK_OUT=1, `bit_clk` is high for exactly one cycle, starting two clock edges after each accepting edge, and is low at all other times.
- R9: Lowering `enable` clears the accumulators and all outputs on the next edge. After `enable` is raised again, the output sequence restarts exactly as it does after reset.
- R10: With CLK_OUT=0, `bit_clk` is tied to 0 and the bit outputs behave as with CLK_OUT=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the loop when high; forces the idle state when low |
| s_valid | input | 1 | Upstream word valid |
| s_ready | output | 1 | Block can accept a word |
| s_data | input | DATA_W | Signed two's-complement input word |
| bit_p | output | 1 | Quantised bit |
| bit_n | output | 1 | Inverted quantised bit (0 when idle) |
| bit_clk | output | 1 | Retiming strobe, high while the bit is stable |

## Verification
`s_ready` depends only on state and `enable`, so the bench samples it 1 ns after driving the inputs, before the edge. The bits are due one edge after the accepting edge, and `bit_clk` is due two edges after it. The effect of a low `enable` is visible after a single edge. The bench advances a reference model of the loop by one step per clock edge, in the same order as the edges occur, and compares every output at the following falling edge. Because of this, each result is checked in exactly the cycle its latency puts it in, whether inputs arrive back-to-back, with gaps, at full scale or across a disable.

// File: rtl/sdm3_pkg.sv
package sdm3_pkg;
  localparam int STAGES      = 3;
  localparam int DEF_DATA_W  = 16;
  localparam int DEF_GUARD_W = 4;
endpackage

// File: rtl/sdm3_integrator.sv
module sdm3_integrator #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic                    fb_one,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] acc
);
  localparam int EXT_W = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] FS_POS = EXT_W'(1) << (DATA_W - 1);
  localparam logic signed [EXT_W-1:0] SAT_HI = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] SAT_LO = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [EXT_W-1:0] sum_ext;
  logic signed [ACC_W-1:0] acc_nxt;

  always_comb begin
    sum_ext = EXT_W'(acc) + EXT_W'(din) - (fb_one ? FS_POS : -FS_POS);
    if (sum_ext > SAT_HI)      acc_nxt = SAT_HI[ACC_W-1:0];
    else if (sum_ext < SAT_LO) acc_nxt = SAT_LO[ACC_W-1:0];
    else                       acc_nxt = sum_ext[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= acc_nxt;
  end

  // R6: adding non-negative terms never lands on a negative value
  assert_no_wrap_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear && !acc[ACC_W-1] && !din[ACC_W-1] && !fb_one |=> !acc[ACC_W-1]);
  // R6: adding negative terms never lands on a non-negative value
  assert_no_wrap_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear && acc[ACC_W-1] && din[ACC_W-1] && fb_one |=> acc[ACC_W-1]);
  // R7
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !step |=> $stable(acc));
  // R9
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc == '0);
endmodule

// File: rtl/sdm3_bitout.sv
module sdm3_bitout #(
  parameter int ACC_W   = 20,
  parameter bit CLK_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    accept,
  input  logic signed [ACC_W-1:0] acc_last,
  output logic                    pend,
  output logic                    bit_p,
  output logic                    bit_n,
  output logic                    bit_clk
);
  logic pend_d;
  logic q_next;

  assign q_next = (acc_last >= 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      pend_d <= 1'b0;
      bit_p  <= 1'b0;
      bit_n  <= 1'b0;
    end else if (!enable) begin
      pend   <= 1'b0;
      pend_d <= 1'b0;
      bit_p  <= 1'b0;
      bit_n  <= 1'b0;
    end else begin
      pend   <= accept;
      pend_d <= pend;
      if (pend) begin
        bit_p <= q_next;
        bit_n <= !q_next;
      end
    end
  end

  generate
    if (CLK_OUT) begin : g_clk
      logic clk_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       clk_q <= 1'b0;
        else if (!enable) clk_q <= 1'b0;
        else              clk_q <= pend_d;
      end
      assign bit_clk = clk_q;
    end else begin : g_noclk
      assign bit_clk = 1'b0;
    end
  endgenerate

  // R3
  assert_compl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_p || bit_n) |-> (bit_p != bit_n));
  // R8
  assert_clk_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clk |=> !bit_clk);
  // R9
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bit_p && !bit_n && !bit_clk && !pend);
  // R7
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !pend |=> $stable(bit_p));
endmodule

// File: rtl/sdm3_modulator.sv
module sdm3_modulator
  import sdm3_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int GUARD_W = DEF_GUARD_W,
  parameter bit CLK_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic signed [DATA_W-1:0] s_data,
  output logic                     bit_p,
  output logic                     bit_n,
  output logic                     bit_clk
);
  localparam int ACC_W = DATA_W + GUARD_W;

  logic pend;
  logic accept;
  logic clear;
  logic signed [ACC_W-1:0] acc [STAGES];
  logic signed [ACC_W-1:0] din [STAGES];

  assign clear   = !enable;
  assign s_ready = enable && !pend;
  assign accept  = s_valid && s_ready;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign din[g] = {{GUARD_W{s_data[DATA_W-1]}}, s_data};
      end else begin : g_chain
        assign din[g] = acc[g-1];
      end
      sdm3_integrator #(
        .DATA_W(DATA_W),
        .ACC_W (ACC_W)
      ) i_int (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (accept),
        .fb_one(bit_p),
        .din   (din[g]),
        .acc   (acc[g])
      );
    end
  endgenerate

  sdm3_bitout #(
    .ACC_W  (ACC_W),
    .CLK_OUT(CLK_OUT)
  ) i_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .accept  (accept),
    .acc_last(acc[STAGES-1]),
    .pend    (pend),
    .bit_p   (bit_p),
    .bit_n   (bit_n),
    .bit_clk (bit_clk)
  );

  // R2
  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> !s_ready);
  // R1
  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !s_ready);
endmodule

// File: tb/test_sdm3_modulator.sv
module test_sdm3_modulator;
  localparam int DW = 16;
  localparam longint FS = 64'sd32768;
  localparam longint HI = 64'sd524287;
  localparam longint LO = -64'sd524288;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic s_valid = 1'b0;
  logic signed [DW-1:0] s_data = '0;
  logic s_ready, bit_p, bit_n, bit_clk;
  logic nr, np, nn, nclk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  longint m_i [3];
  bit m_bp, m_bn, m_pend, m_pend_d, m_clk;

  always #4 clk = ~clk;

  sdm3_modulator #(.DATA_W(DW), .GUARD_W(4), .CLK_OUT(1'b1)) i_sdm3_modulator (
    .clk(clk), .rst_n(rst_n), .enable(enable), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .bit_p(bit_p), .bit_n(bit_n), .bit_clk(bit_clk));

  sdm3_modulator #(.DATA_W(DW), .GUARD_W(4), .CLK_OUT(1'b0)) i_noclk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .s_valid(s_valid), .s_ready(nr),
    .s_data(s_data), .bit_p(np), .bit_n(nn), .bit_clk(nclk));

  function automatic longint sat(input longint v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 3; k++) m_i[k] = 0;
    m_bp = 0; m_bn = 0; m_pend = 0; m_pend_d = 0; m_clk = 0;
  endtask

  // one clock edge; called at a falling edge
  task automatic step(input bit en, input bit vld, input logic signed [DW-1:0] d);
    bit take, nxt_clk;
    longint v, n0, n1, n2;
    enable = en; s_valid = vld; s_data = d;
    #1;
    chk(s_ready, en && !m_pend, "R2 s_ready");
    take = en && vld && !m_pend;
    @(posedge clk);
    if (!en) model_clear();
    else begin
      nxt_clk = m_pend_d;
      m_pend_d = m_pend;
      if (m_pend) begin m_bp = (m_i[2] >= 0); m_bn = !m_bp; end
      if (take) begin
        v = m_bp ? FS : -FS;
        n0 = sat(m_i[0] + longint'(d) - v);
        n1 = sat(m_i[1] + m_i[0] - v);
        n2 = sat(m_i[2] + m_i[1] - v);
        m_i[0] = n0; m_i[1] = n1; m_i[2] = n2;
      end
      m_pend = take;
      m_clk = nxt_clk;
    end
    @(negedge clk);
    chk(bit_p, m_bp, "R4 R5 R6 R7 bit_p");
    chk(bit_n, m_bn, "R3 R9 bit_n");
    chk(bit_clk, m_clk, "R8 bit_clk");
    chk(nclk, 1'b0, "R10 bit_clk tied low");
    chk(np, m_bp, "R10 bit_p without strobe");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0003));
    model_clear();
    repeat (3) @(negedge clk);
    chk(bit_p, 1'b0, "R1 reset bit_p");
    chk(bit_n, 1'b0, "R1 reset bit_n");
    chk(bit_clk, 1'b0, "R1 reset bit_clk");
    chk(s_ready, 1'b0, "R1 reset s_ready");
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 16'sd1000);
    // directed: zero input, continuous valid
    for (int k = 0; k < 60; k++) step(1'b1, 1'b1, '0);
    // directed: small positive level with gaps
    for (int k = 0; k < 80; k++) step(1'b1, k[1], 16'sd4000);
    // random traffic
    for (int k = 0; k < 2500; k++) begin
      logic [31:0] r = $urandom;
      step(r[31:26] != 6'd0, r[17:16] != 2'b00, r[15:0]);
    end
    // saturation: full-scale positive then negative
    for (int k = 0; k < 300; k++) step(1'b1, 1'b1, 16'sh7fff);
    for (int k = 0; k < 300; k++) step(1'b1, 1'b1, 16'sh8000);
    // R7: no words offered, state held
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 16'sh1234);
    // R9: disable mid-stream, then restart from idle
    step(1'b0, 1'b1, 16'sh0100);
    chk(bit_p | bit_n | bit_clk, 1'b0, "R9 idle after disable");
    for (int k = 0; k < 200; k++) step(1'b1, 1'b1, 16'sh2000);
    step(1'b0, 1'b0, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule